// File: doc/BRIEF.md
# Tag-Broadcast Reservation Station Array

This block holds instructions that wait for their operands in front of two arithmetic units, an adder and a multiplier. Each waiting slot (station) keeps two operand fields. Each field holds a ready bit, a producer tag and a data word. A small floating-point register file carries the same three fields per entry.

When an instruction is dispatched, the following happens in the same step:
- Each source register hands over either its value or the tag of the station that will produce it.
- The destination register is re-labelled with the new station's tag and marked not ready.

A single result bus carries one tag and one value per cycle. Every waiting operand field, and every register entry whose tag matches, captures the value in that same cycle. A station issues to its unit once both operands are ready. The units are fixed-latency stubs, and the multiplier wins the bus when both finish together. The usual front end places decoded instructions here with dispatch. The architectural register values can be observed through a read port.

Top module: `rs_array`

## Requirements
- R1: After reset every register entry is ready with tag 0 and data equal to its index plus one. The bus is idle, and a free station is reported for both units.
- R2: Stations are encoded by tag: adder stations are tags 1, 2 and 3, and multiplier stations are tags 4 and 5 (tag 0 is never used).
  - `dispOp` 0 selects the adder and 1 selects the multiplier.
  - `dispReady` is high when the selected unit has a free station.
  - A dispatch takes the lowest-numbered free station of that unit.
- R3: In the cycle after a dispatch, the destination register reads not ready, and its tag is the station's tag.
- R4: At dispatch, each source operand takes its value from one of three places:
  - the register value, when the register is ready;
  - the bus value, when the bus broadcasts the register's tag in that same cycle;
  - otherwise, the register's tag, and the operand waits.
- R5: During a broadcast, every not-ready operand field or register entry whose tag equals the bus tag captures the bus data and becomes ready.
- R6: A station issues when both of its operands are ready, it has not issued yet, and its unit is idle. At most one station per unit issues per cycle, and the lowest-numbered candidate goes first.
- R7: The adder result (a+b) is available ADD_LAT cycles after issue. The multiplier result (a*b, truncated to the data width) is available MUL_LAT cycles after issue.
- R8: When both units have a result in the same cycle, the multiplier drives the bus. The adder keeps its result and broadcasts in a later cycle.
- R9: A station stays occupied until its own tag has been broadcast. It can accept a new dispatch from the cycle after that broadcast.
- R10: Once all work has drained, every register holds the value that executing the dispatched instructions one by one in program order would produce.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dispValid | input | 1 | Dispatch request |
| dispOp | input | 1 | Unit select: 0 adder, 1 multiplier |
| dispSrcA | input | 3 | First source register |
| dispSrcB | input | 3 | Second source register |
| dispDst | input | 3 | Destination register |
| dispReady | output | 1 | Free station exists for the selected unit |
| busValid | output | 1 | Result bus carries a broadcast |
| busTag | output | 3 | Tag being broadcast |
| busData | output | 16 | Value being broadcast |
| rdAddr | input | 3 | Register read address |
| rdPresent | output | 1 | Read register is ready |
| rdTag | output | 3 | Read register tag |
| rdData | output | 16 | Read register data |

## Verification
The assertions check the following on every cycle:
- the bus tag stays in the station range;
- the multiplier takes the bus in a tie, and the adder's result persists into the next cycle;
- a station is released only right after a broadcast of its own tag;
- an accepted dispatch grows the set of occupied stations.

Operand capture, the same-cycle bypass at dispatch, renaming order and the final register values are shown only by the bench's scenarios. Those scenarios compare the drained register file against a sequential model, and they time a dispatch to land in the very cycle its source is broadcast.

// File: rtl/rs_array_pkg.sv
package rs_array_pkg;
  localparam int ADD_RS   = 3;
  localparam int MUL_RS   = 2;
  localparam int NUM_RS   = ADD_RS + MUL_RS;
  localparam int TAG_W    = $clog2(NUM_RS + 1);
  localparam int DATA_W   = 16;
  localparam int NUM_REGS = 8;
  localparam int REG_W    = $clog2(NUM_REGS);
  localparam int ADD_LAT  = 2;
  localparam int MUL_LAT  = 3;

  typedef logic [TAG_W-1:0]  tag_t;
  typedef logic [DATA_W-1:0] data_t;
  typedef logic [REG_W-1:0]  regIdx_t;

  typedef struct packed {
    logic  ready;
    tag_t  tag;
    data_t data;
  } field_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic dispWe;
    tag_t dispTag;
    logic addIssue;
    tag_t addTag;
    logic mulIssue;
    tag_t mulTag;
    logic busValid;
    tag_t busTag;
    logic busFromMul;
  } strobe_t;
endpackage

// File: rtl/rs_array_timer.sv
module rs_array_timer
  import rs_array_pkg::*;
#(
  parameter int LAT = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic start,
  input  tag_t startTag,
  input  logic grant,
  output logic idle,
  output logic done,
  output tag_t tag
);
  localparam int CW = $clog2(LAT + 1);

  logic          busy;
  logic [CW-1:0] cnt;

  assign idle = !busy;
  assign done = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      cnt  <= '0;
      tag  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= CW'(LAT - 1);
      tag  <= startTag;
    end else if (busy && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end else if (done && grant) begin
      busy <= 1'b0;
    end
  end
endmodule

// File: rtl/rs_array_ctrl.sv
module rs_array_ctrl
  import rs_array_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              dispValid,
  input  logic              dispOp,
  input  logic [NUM_RS-1:0] rsReady,
  output logic              dispReady,
  output strobe_t           strobes,
  output logic [NUM_RS-1:0] stBusy,
  output logic              addDone,
  output logic              mulDone
);
  logic [NUM_RS-1:0] stExec;
  logic addFree, mulFree, addCand, mulCand;
  tag_t addFreeTag, mulFreeTag, addCandTag, mulCandTag;
  logic addIdle, mulIdle;
  tag_t addUnitTag, mulUnitTag;

  // Lowest-index selection: scan downward, last hit wins
  always_comb begin
    addFree = 1'b0; addFreeTag = '0; addCand = 1'b0; addCandTag = '0;
    mulFree = 1'b0; mulFreeTag = '0; mulCand = 1'b0; mulCandTag = '0;
    for (int i = ADD_RS - 1; i >= 0; i--) begin
      if (!stBusy[i]) begin addFree = 1'b1; addFreeTag = tag_t'(i + 1); end
      if (stBusy[i] && !stExec[i] && rsReady[i]) begin
        addCand = 1'b1; addCandTag = tag_t'(i + 1);
      end
    end
    for (int i = NUM_RS - 1; i >= ADD_RS; i--) begin
      if (!stBusy[i]) begin mulFree = 1'b1; mulFreeTag = tag_t'(i + 1); end
      if (stBusy[i] && !stExec[i] && rsReady[i]) begin
        mulCand = 1'b1; mulCandTag = tag_t'(i + 1);
      end
    end
  end

  assign dispReady = dispOp ? mulFree : addFree;

  always_comb begin
    strobes.dispWe     = dispValid && dispReady;
    strobes.dispTag    = dispOp ? mulFreeTag : addFreeTag;
    strobes.addIssue   = addCand && addIdle;
    strobes.addTag     = addCandTag;
    strobes.mulIssue   = mulCand && mulIdle;
    strobes.mulTag     = mulCandTag;
    strobes.busValid   = addDone || mulDone;
    strobes.busFromMul = mulDone;
    strobes.busTag     = mulDone ? mulUnitTag : addUnitTag;
  end

  rs_array_timer #(.LAT(ADD_LAT)) addTimer (
    .clk(clk), .rstN(rstN), .start(strobes.addIssue), .startTag(strobes.addTag),
    .grant(addDone && !mulDone), .idle(addIdle), .done(addDone), .tag(addUnitTag)
  );

  rs_array_timer #(.LAT(MUL_LAT)) mulTimer (
    .clk(clk), .rstN(rstN), .start(strobes.mulIssue), .startTag(strobes.mulTag),
    .grant(mulDone), .idle(mulIdle), .done(mulDone), .tag(mulUnitTag)
  );

  for (genvar g = 0; g < NUM_RS; g++) begin : gStation
    localparam tag_t MY_TAG = tag_t'(g + 1);
    always_ff @(posedge clk) begin
      if (!rstN) begin
        stBusy[g] <= 1'b0;
        stExec[g] <= 1'b0;
      end else if (strobes.busValid && strobes.busTag == MY_TAG) begin
        stBusy[g] <= 1'b0;
        stExec[g] <= 1'b0;
      end else if (strobes.dispWe && strobes.dispTag == MY_TAG) begin
        stBusy[g] <= 1'b1;
        stExec[g] <= 1'b0;
      end else if ((strobes.addIssue && strobes.addTag == MY_TAG) ||
                   (strobes.mulIssue && strobes.mulTag == MY_TAG)) begin
        stExec[g] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rs_array_dp.sv
module rs_array_dp
  import rs_array_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  regIdx_t           srcA,
  input  regIdx_t           srcB,
  input  regIdx_t           dst,
  input  regIdx_t           rdAddr,
  output logic [NUM_RS-1:0] rsReady,
  output data_t             busData,
  output logic              rdPresent,
  output tag_t              rdTag,
  output data_t             rdData
);
  field_t regs [NUM_REGS];
  field_t opA  [NUM_RS];
  field_t opB  [NUM_RS];
  data_t  addA, addB, mulA, mulB, mulProd;
  field_t pickA, pickB;
  tag_t   addIdx, mulIdx;

  function automatic field_t resolve(field_t r, logic bv, tag_t bt, data_t bd);
    field_t f;
    if (r.ready) begin
      f.ready = 1'b1; f.tag = '0; f.data = r.data;
    end else if (bv && bt == r.tag) begin
      f.ready = 1'b1; f.tag = r.tag; f.data = bd;
    end else begin
      f.ready = 1'b0; f.tag = r.tag; f.data = '0;
    end
    return f;
  endfunction

  assign mulProd = mulA * mulB;
  assign busData = strobes.busFromMul ? mulProd : (addA + addB);
  assign pickA   = resolve(regs[srcA], strobes.busValid, strobes.busTag, busData);
  assign pickB   = resolve(regs[srcB], strobes.busValid, strobes.busTag, busData);
  assign addIdx  = strobes.addTag - tag_t'(1);
  assign mulIdx  = strobes.mulTag - tag_t'(1);

  always_comb
    for (int i = 0; i < NUM_RS; i++) rsReady[i] = opA[i].ready && opB[i].ready;

  assign rdPresent = regs[rdAddr].ready;
  assign rdTag     = regs[rdAddr].tag;
  assign rdData    = regs[rdAddr].data;

  function automatic field_t snoop(field_t f, logic bv, tag_t bt, data_t bd);
    field_t n = f;
    if (!f.ready && bv && f.tag == bt) begin
      n.ready = 1'b1; n.data = bd;
    end
    return n;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < NUM_REGS; r++) begin
        regs[r].ready <= 1'b1;
        regs[r].tag   <= '0;
        regs[r].data  <= data_t'(r + 1);
      end
      for (int i = 0; i < NUM_RS; i++) begin
        opA[i] <= '0;
        opB[i] <= '0;
      end
      addA <= '0; addB <= '0; mulA <= '0; mulB <= '0;
    end else begin
      for (int r = 0; r < NUM_REGS; r++) begin
        if (strobes.dispWe && dst == regIdx_t'(r)) begin
          regs[r].ready <= 1'b0;
          regs[r].tag   <= strobes.dispTag;
        end else begin
          regs[r] <= snoop(regs[r], strobes.busValid, strobes.busTag, busData);
        end
      end
      for (int i = 0; i < NUM_RS; i++) begin
        if (strobes.dispWe && strobes.dispTag == tag_t'(i + 1)) begin
          opA[i] <= pickA;
          opB[i] <= pickB;
        end else begin
          opA[i] <= snoop(opA[i], strobes.busValid, strobes.busTag, busData);
          opB[i] <= snoop(opB[i], strobes.busValid, strobes.busTag, busData);
        end
      end
      if (strobes.addIssue) begin
        addA <= opA[addIdx].data;
        addB <= opB[addIdx].data;
      end
      if (strobes.mulIssue) begin
        mulA <= opA[mulIdx].data;
        mulB <= opB[mulIdx].data;
      end
    end
  end
endmodule

// File: rtl/rs_array.sv
module rs_array
  import rs_array_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              dispValid,
  input  logic              dispOp,
  input  logic [REG_W-1:0]  dispSrcA,
  input  logic [REG_W-1:0]  dispSrcB,
  input  logic [REG_W-1:0]  dispDst,
  output logic              dispReady,
  output logic              busValid,
  output logic [TAG_W-1:0]  busTag,
  output logic [DATA_W-1:0] busData,
  input  logic [REG_W-1:0]  rdAddr,
  output logic              rdPresent,
  output logic [TAG_W-1:0]  rdTag,
  output logic [DATA_W-1:0] rdData
);
  strobe_t           strobes;
  logic [NUM_RS-1:0] rsReady;
  logic [NUM_RS-1:0] stBusy;
  logic              addDone, mulDone;

  rs_array_ctrl ctrl (
    .clk(clk), .rstN(rstN), .dispValid(dispValid), .dispOp(dispOp),
    .rsReady(rsReady), .dispReady(dispReady), .strobes(strobes),
    .stBusy(stBusy), .addDone(addDone), .mulDone(mulDone)
  );

  rs_array_dp dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .srcA(dispSrcA), .srcB(dispSrcB),
    .dst(dispDst), .rdAddr(rdAddr), .rsReady(rsReady), .busData(busData),
    .rdPresent(rdPresent), .rdTag(rdTag), .rdData(rdData)
  );

  assign busValid = strobes.busValid;
  assign busTag   = strobes.busTag;
endmodule

// File: rtl/rs_array_chk.sv
module rs_array_chk
  import rs_array_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              dispValid,
  input logic              dispReady,
  input logic              busValid,
  input tag_t              busTag,
  input logic [NUM_RS-1:0] stBusy,
  input logic              addDone,
  input logic              mulDone
);
  assert_tag_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    busValid |-> (busTag != '0 && int'(busTag) <= NUM_RS));

  assert_dispatch_fills_R2: assert property (@(posedge clk) disable iff (!rstN)
    (dispValid && dispReady) |=>
      ($countones(stBusy) == $past($countones(stBusy)) + 1 - ($past(busValid) ? 1 : 0)));

  assert_mul_first_R8: assert property (@(posedge clk) disable iff (!rstN)
    (addDone && mulDone) |-> (busValid && int'(busTag) > ADD_RS));

  assert_loser_holds_R8: assert property (@(posedge clk) disable iff (!rstN)
    (addDone && mulDone) |=> addDone);

  for (genvar g = 0; g < NUM_RS; g++) begin : gFree
    assert_free_after_bcast_R9: assert property (@(posedge clk) disable iff (!rstN)
      $fell(stBusy[g]) |-> $past(busValid && busTag == tag_t'(g + 1)));
  end
endmodule

bind rs_array rs_array_chk chk (
  .clk(clk), .rstN(rstN), .dispValid(dispValid), .dispReady(dispReady),
  .busValid(busValid), .busTag(busTag), .stBusy(stBusy),
  .addDone(addDone), .mulDone(mulDone)
);

// File: tb/rs_array_test.sv
module rs_array_test;
  import rs_array_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dispValid = 1'b0, dispOp = 1'b0;
  logic [REG_W-1:0] dispSrcA = '0, dispSrcB = '0, dispDst = '0, rdAddr = '0;
  logic dispReady, busValid, rdPresent;
  logic [TAG_W-1:0] busTag, rdTag;
  logic [DATA_W-1:0] busData, rdData;

  int nChecks = 0, nFail = 0;
  logic [DATA_W-1:0] mdl [NUM_REGS];
  int busLog [64];
  int busCount = 0;

  always #4 clk = ~clk;

  rs_array uut (
    .clk(clk), .rstN(rstN), .dispValid(dispValid), .dispOp(dispOp),
    .dispSrcA(dispSrcA), .dispSrcB(dispSrcB), .dispDst(dispDst),
    .dispReady(dispReady), .busValid(busValid), .busTag(busTag), .busData(busData),
    .rdAddr(rdAddr), .rdPresent(rdPresent), .rdTag(rdTag), .rdData(rdData)
  );

  always @(negedge clk)
    if (rstN && busValid && busCount < 64) begin
      busLog[busCount] = int'(busTag);
      busCount++;
    end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] compute(input bit op, input logic [DATA_W-1:0] a,
                                                input logic [DATA_W-1:0] b);
    return op ? DATA_W'(a * b) : DATA_W'(a + b);
  endfunction

  // Called at a negedge; returns at the negedge after acceptance
  task automatic send(input bit op, input int a, input int b, input int d);
    dispOp = op; dispSrcA = REG_W'(a); dispSrcB = REG_W'(b); dispDst = REG_W'(d);
    dispValid = 1'b0;
    #1;
    while (!dispReady) begin @(negedge clk); #1; end
    dispValid = 1'b1;
    mdl[d] = compute(op, mdl[a], mdl[b]);
    @(negedge clk);
    dispValid = 1'b0;
  endtask

  task automatic readReg(input int r, output bit p, output int t, output int v);
    rdAddr = REG_W'(r);
    #1;
    p = rdPresent; t = int'(rdTag); v = int'(rdData);
  endtask

  task automatic drainCompare(input string req);
    bit p; int t, v;
    repeat (80) @(negedge clk);
    for (int r = 0; r < NUM_REGS; r++) begin
      readReg(r, p, t, v);
      chk(p, {req, " ready after drain"}, int'(p), 1);
      chk(v == int'(mdl[r]), {req, " value"}, v, int'(mdl[r]));
    end
  endtask

  initial begin
    #(8 * 150000);
    nFail++; nChecks++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    bit p; int t, v;
    void'($urandom(32'd2024));
    for (int r = 0; r < NUM_REGS; r++) mdl[r] = DATA_W'(r + 1);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int r = 0; r < NUM_REGS; r++) begin
      readReg(r, p, t, v);
      chk(p && t == 0 && v == r + 1, "R1 register reset", v, r + 1);
    end
    dispOp = 1'b0; #1; chk(dispReady, "R1 adder free", int'(dispReady), 1);
    dispOp = 1'b1; #1; chk(dispReady, "R1 mul free", int'(dispReady), 1);
    chk(!busValid, "R1 bus idle", int'(busValid), 0);
    @(negedge clk);

    // R3 rename of destination
    send(1'b0, 1, 2, 3);
    readReg(3, p, t, v);
    chk(!p, "R3 dst not ready", int'(p), 0);
    chk(t == 1, "R3 dst tag", t, 1);
    drainCompare("R5");

    // R8 bus priority: mul and add finish together
    busCount = 0;
    send(1'b1, 0, 1, 4);
    send(1'b0, 2, 5, 6);
    repeat (10) @(negedge clk);
    chk(busCount == 2, "R8 broadcast count", busCount, 2);
    chk(busLog[0] == 4, "R8 mul first", busLog[0], 4);
    chk(busLog[1] == 1, "R8 add later", busLog[1], 1);
    drainCompare("R7");

    // R2 / R9 station occupancy
    send(1'b0, 0, 1, 5);
    send(1'b0, 2, 3, 6);
    send(1'b0, 4, 7, 7);
    dispOp = 1'b0; #1;
    chk(!dispReady, "R9 adder full while tag 1 broadcasts", int'(dispReady), 0);
    chk(busValid && busTag == 1, "R9 tag 1 on bus", int'(busTag), 1);
    dispOp = 1'b1; #1;
    chk(dispReady, "R2 mul still free", int'(dispReady), 1);
    readReg(7, p, t, v);
    chk(!p && t == 3, "R2 third adder station tag", t, 3);
    @(negedge clk);
    dispOp = 1'b0; #1;
    chk(dispReady, "R9 station freed after broadcast", int'(dispReady), 1);
    drainCompare("R6");

    // R4 bypass: dispatch in the cycle the source is broadcast
    send(1'b0, 0, 1, 2);
    @(negedge clk);
    @(negedge clk);
    chk(busValid && busTag == 1, "R4 source on bus", int'(busTag), 1);
    send(1'b1, 2, 2, 3);
    readReg(3, p, t, v);
    chk(!p && t == 4, "R4 consumer tag", t, 4);
    drainCompare("R4");

    // R10 random programs
    for (int round = 0; round < 3; round++) begin
      for (int k = 0; k < 30; k++) begin
        send(1'($urandom % 2), int'($urandom % NUM_REGS), int'($urandom % NUM_REGS),
             int'($urandom % NUM_REGS));
        if ($urandom % 4 == 0) @(negedge clk);
      end
      drainCompare("R10");
    end

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule